// File: doc/BRIEF.md
# Class-D Amplifier Power-Up Sequencer

This block brings a pair of differentially driven class-D power stages up in a safe order and keeps them safe afterwards. It derives the sawtooth sync clock for the amplifiers from the high-frequency clock. A 2-bit select picks the divide ratio, and one encoding of that select turns the clock off. On a start request the block holds both DAC codes at midscale, so the differential drive is zero. It then enables the sync clock, waits 100 µs, releases both shutdowns, and waits another 100 µs. Only after that does it pass the user's DAC codes through.

After start-up either amplifier can be shut down at any moment. When both are shut down, the sync clock is stopped. Thermal or current-limit events from an active channel are stretched into a fault status that is at least 500 ns wide. That status is forced low while both amplifiers are shut down. It can be polled, or it can raise an interrupt when the interrupt enable is set. The delays are counted in cycles of `clk`, derived from the `CLK_HZ` parameter and rounded up.

Top module: `cdamp_seq`

## Requirements
- R1: After reset both `amp_shdn` bits are 1, `sync_clk`, `ready`, `fault_stat` and `irq` are 0, both DAC codes are 512, and the divider select is 0.
- R2: The divider select maps 0 to off, 1 to a period of 2, 2 to a period of 3 and 3 to a period of 4 `clk` cycles. In each period `sync_clk` is high for the first floor(period/2) cycles.
- R3: A new divider select, or a stop of the sync clock, takes effect only at the end of the current sync period. A select written while the clock is off is picked up on the next cycle.
- R4: A `start` pulse while idle starts the sync clock. Both shutdowns stay asserted and both codes stay at 512 for T_UP = ceil(CLK_HZ·100 µs) cycles, and then the shutdowns are released.
- R5: T_UP cycles after the release, `ready` goes high. From then on, each DAC code output equals its user code (offset binary, 512 means zero differential output). Before that, each code output is 512.
- R6: Once released, `amp_shdn[i]` follows `shdn_req[i]` at any time.
- R7: After release, `sync_clk` is stopped (at a period boundary) whenever both shutdown requests are high. It restarts when either request drops.
- R8: A fault event on a channel that is not shut down sets `fault_stat` on the next cycle. The status stays high for T_FLT = ceil(CLK_HZ·500 ns) cycles after the last event cycle.
- R9: Events on a shut-down channel are ignored, and `fault_stat` is cleared on the cycle after both amplifiers are shut down.
- R10: `irq` is high exactly when `fault_stat` and `irq_en` are both high.
- R11: A `start` pulse while the sequence is running or complete has no effect on its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-frequency clock, also the sync divider source |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the divider select |
| cfg_div_sel | input | SEL_W | Divider select value (0 = off) |
| start | input | 1 | Begin the power-up order (used only while idle) |
| shdn_req | input | NCH | Per-channel shutdown request, active high |
| user_codes | input | NCH·DAC_W | User DAC codes, channel 0 in the low bits |
| fault_evt | input | NCH | Per-channel thermal or current-limit event |
| irq_en | input | 1 | Fault interrupt enable |
| amp_shdn | output | NCH | Shutdown drive to each amplifier |
| sync_clk | output | 1 | Sawtooth sync clock |
| dac_codes | output | NCH·DAC_W | Codes to the DACs |
| ready | output | 1 | Power-up order complete |
| fault_stat | output | 1 | Stretched fault status |
| irq | output | 1 | Fault interrupt |

## Verification
The assertions assume that `start`, `shdn_req`, `fault_evt` and the configuration inputs are synchronous to `clk`. They also assume reset is held for more than one cycle, so that every `$past` value comes from reset state. The bench drives all inputs on the falling edge and holds reset for several cycles. It runs the block with a scaled `CLK_HZ` so that T_UP is 1000 cycles and T_FLT is 5 cycles, which keeps both delays and the stretch window inside a short run.

// File: rtl/cdamp_pkg.sv
// Shared types and helpers for the class-D power-up sequencer.
package cdamp_pkg;

    // Phases of the power-up order.
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_CLKWAIT = 2'd1,
        PH_RELWAIT = 2'd2,
        PH_RUN     = 2'd3
    } pwr_phase_e;

    // Integer division that rounds up.
    function automatic int unsigned cdiv(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/cdamp_syncgen.sv
// Sync clock divider.
// A select of 0 means off; a select of s gives a period of s+1 clk cycles,
// high for the first floor((s+1)/2) cycles. The active select is sampled
// only at a period boundary, so the output never glitches.
// Assumes run_i and sel_i are synchronous to clk.
module cdamp_syncgen #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             sync_o
);
    logic [SEL_W-1:0] act_q, act_d;
    logic [SEL_W-1:0] cnt_q, cnt_d;
    logic [SEL_W:0]   period_d;
    logic             sync_q;

    // Next active select and phase count.
    always_comb begin
        act_d = act_q;
        cnt_d = cnt_q;
        if (act_q == '0) begin
            cnt_d = '0;
            act_d = run_i ? sel_i : '0;
        end else if (cnt_q == act_q) begin
            cnt_d = '0;
            act_d = run_i ? sel_i : '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
        period_d = {1'b0, act_d} + (SEL_W+1)'(1);
    end

    // Register the state and the decoded output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= '0;
            cnt_q  <= '0;
            sync_q <= 1'b0;
        end else begin
            act_q  <= act_d;
            cnt_q  <= cnt_d;
            sync_q <= (act_d != '0) && ({1'b0, cnt_d} < (period_d >> 1));
        end
    end

    assign sync_o = sync_q;

    // The select may change only at the end of a period.
    assert_boundary_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q != '0 && cnt_q != act_q) |=> (act_q == $past(act_q)));

    // Stopped and not asked to run: output stays low.
    assert_quiet_when_stopped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q == '0 && !run_i) |=> !sync_o);

endmodule

// File: rtl/cdamp_fault_stretch.sv
// Fault pulse stretcher.
// An event on a channel that is not shut down reloads a down-counter.
// The status is high while the counter is non-zero. Shutdown of all
// channels clears the status.
// Assumes the events are synchronous to clk.
module cdamp_fault_stretch #(
    parameter int NCH     = 2,
    parameter int STRETCH = 63
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] evt_i,
    input  logic [NCH-1:0] shut_i,
    output logic           stat_o
);
    localparam int CW = $clog2(STRETCH + 1);

    logic [NCH-1:0] qual;
    logic           all_shut;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic           stat_q;

    // Qualify each channel's event by its shutdown state.
    for (genvar g = 0; g < NCH; g++) begin : g_qual
        assign qual[g] = evt_i[g] & ~shut_i[g];
    end
    assign all_shut = &shut_i;

    // Next counter value: clear, reload, or count down.
    always_comb begin
        if (all_shut)          cnt_d = '0;
        else if (|qual)        cnt_d = CW'(STRETCH);
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
        else                   cnt_d = cnt_q;
    end

    // Counter and registered status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            stat_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            stat_q <= (cnt_d != '0);
        end
    end

    assign stat_o = stat_q;

    assert_set_on_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|qual && !all_shut) |=> stat_o);

    assert_fall_after_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_o) |-> ($past(all_shut) || $past(cnt_q) == CW'(1)));

    assert_low_in_shutdown_R9: assert property (@(posedge clk) disable iff (!rst_n)
        all_shut |=> !stat_o);

endmodule

// File: rtl/cdamp_powerup_fsm.sv
// Power-up order controller.
// From idle, a start pulse enables the sync clock for T_UP cycles with
// both shutdowns held, then releases them for T_UP cycles, then reports
// ready. It never returns to idle except through reset.
module cdamp_powerup_fsm #(
    parameter int T_UP = 12500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic clk_phase_o,
    output logic released_o,
    output logic ready_o
);
    import cdamp_pkg::*;

    localparam int TW = $clog2(T_UP + 1);

    pwr_phase_e    phase_q;
    logic [TW-1:0] tmr_q;

    // Phase and delay timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            tmr_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: if (start_i) begin
                    phase_q <= PH_CLKWAIT;
                    tmr_q   <= TW'(T_UP - 1);
                end
                PH_CLKWAIT: if (tmr_q == '0) begin
                    phase_q <= PH_RELWAIT;
                    tmr_q   <= TW'(T_UP - 1);
                end else begin
                    tmr_q <= tmr_q - 1'b1;
                end
                PH_RELWAIT: if (tmr_q == '0) begin
                    phase_q <= PH_RUN;
                end else begin
                    tmr_q <= tmr_q - 1'b1;
                end
                default: phase_q <= PH_RUN;
            endcase
        end
    end

    assign clk_phase_o = (phase_q == PH_CLKWAIT);
    assign released_o  = (phase_q == PH_RELWAIT) || (phase_q == PH_RUN);
    assign ready_o     = (phase_q == PH_RUN);

    assert_order_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_CLKWAIT) |=> (phase_q == PH_CLKWAIT || phase_q == PH_RELWAIT));

    assert_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_IDLE) |=> (phase_q != PH_IDLE));

endmodule

// File: rtl/cdamp_seq.sv
// Class-D power-up sequencer top.
// Holds the divider select, sequences power-up, gates the sync clock,
// applies per-channel shutdowns, muxes DAC codes and stretches faults.
// Assumes every input is synchronous to clk.
module cdamp_seq #(
    parameter int CLK_HZ = 125_000_000,
    parameter int NCH    = 2,
    parameter int DAC_W  = 10,
    parameter int SEL_W  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [SEL_W-1:0]     cfg_div_sel,
    input  logic                 start,
    input  logic [NCH-1:0]       shdn_req,
    input  logic [NCH*DAC_W-1:0] user_codes,
    input  logic [NCH-1:0]       fault_evt,
    input  logic                 irq_en,
    output logic [NCH-1:0]       amp_shdn,
    output logic                 sync_clk,
    output logic [NCH*DAC_W-1:0] dac_codes,
    output logic                 ready,
    output logic                 fault_stat,
    output logic                 irq
);
    import cdamp_pkg::*;

    localparam int unsigned T_UP  = cdiv(CLK_HZ, 10_000);
    localparam int unsigned T_FLT = cdiv(CLK_HZ, 2_000_000);
    localparam logic [DAC_W-1:0] MID = {1'b1, {(DAC_W-1){1'b0}}};

    logic [SEL_W-1:0] div_sel_q;
    logic             clk_phase, released, sync_run;

    // Divider select register.
    always_ff @(posedge clk) begin
        if (!rst_n)      div_sel_q <= '0;
        else if (cfg_we) div_sel_q <= cfg_div_sel;
    end

    cdamp_powerup_fsm #(.T_UP(T_UP)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .clk_phase_o (clk_phase),
        .released_o  (released),
        .ready_o     (ready)
    );

    // Run the sync clock while warming up, or after release unless all are shut.
    assign sync_run = clk_phase | (released & ~(&shdn_req));

    cdamp_syncgen #(.SEL_W(SEL_W)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (sync_run),
        .sel_i  (div_sel_q),
        .sync_o (sync_clk)
    );

    // Per-channel shutdown drive and DAC code selection.
    for (genvar g = 0; g < NCH; g++) begin : g_chan
        assign amp_shdn[g] = ~released | shdn_req[g];
        assign dac_codes[g*DAC_W +: DAC_W] = ready ? user_codes[g*DAC_W +: DAC_W] : MID;
    end

    cdamp_fault_stretch #(.NCH(NCH), .STRETCH(T_FLT)) flt_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (fault_evt),
        .shut_i (amp_shdn),
        .stat_o (fault_stat)
    );

    assign irq = fault_stat & irq_en;

    // Before the order starts, the divider has never been asked to run.
    assert_sync_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!released && !clk_phase) |-> !sync_clk);

endmodule

// File: tb/cdamp_seq_tb_top.sv
// Bench for cdamp_seq: a behavioural reference model compared every cycle.
module cdamp_seq_tb_top;

    localparam int CLK_HZ = 10_000_000;
    localparam int TU     = 1000;  // 100 us at 10 MHz
    localparam int TF     = 5;     // 500 ns at 10 MHz

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_div_sel = '0;
    logic        start = 1'b0;
    logic [1:0]  shdn_req = '0;
    logic [19:0] user_codes = '0;
    logic [1:0]  fault_evt = '0;
    logic        irq_en = 1'b0;
    logic [1:0]  amp_shdn;
    logic        sync_clk;
    logic [19:0] dac_codes;
    logic        ready, fault_stat, irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cdamp_seq #(.CLK_HZ(CLK_HZ)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_div_sel(cfg_div_sel),
        .start(start), .shdn_req(shdn_req), .user_codes(user_codes),
        .fault_evt(fault_evt), .irq_en(irq_en), .amp_shdn(amp_shdn),
        .sync_clk(sync_clk), .dac_codes(dac_codes), .ready(ready),
        .fault_stat(fault_stat), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model state.
    int m_t = -1;     // cycles since accepted start, -1 while idle
    int m_sel = 0;
    int m_per = 0;    // active sync period, 0 when stopped
    int m_ph = 0;
    int m_fc = 0;

    // Advance the model on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_t = -1; m_sel = 0; m_per = 0; m_ph = 0; m_fc = 0;
        end else begin
            bit rel, gate;
            logic [1:0] shd;
            rel  = (m_t >= TU);
            gate = (m_t >= 0 && m_t < TU) || (rel && shdn_req != 2'b11);
            shd  = rel ? shdn_req : 2'b11;
            if (m_per == 0) begin
                m_ph = 0;
                m_per = (gate && m_sel != 0) ? m_sel + 1 : 0;
            end else if (m_ph == m_per - 1) begin
                m_ph = 0;
                m_per = (gate && m_sel != 0) ? m_sel + 1 : 0;
            end else begin
                m_ph++;
            end
            if (shd == 2'b11)                   m_fc = 0;
            else if ((fault_evt & ~shd) != 2'b00) m_fc = TF;
            else if (m_fc > 0)                  m_fc--;
            if (cfg_we) m_sel = cfg_div_sel;
            if (m_t < 0 && start) m_t = 0;
            else if (m_t >= 0 && m_t < 2*TU) m_t++;
        end
    end

    // Compare all outputs shortly after each edge.
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            bit rel, rdy, fs;
            logic [1:0] shd;
            rel = (m_t >= TU);
            rdy = (m_t >= 2*TU);
            shd = rel ? shdn_req : 2'b11;
            fs  = (m_fc != 0);
            chk("R4,R6,R11 amp_shdn", amp_shdn, shd);
            chk("R2,R3,R7 sync_clk", sync_clk, (m_per != 0 && m_ph < m_per/2));
            chk("R5 ready", ready, rdy);
            chk("R5 dac_codes", dac_codes, rdy ? user_codes : {10'd512, 10'd512});
            chk("R8,R9 fault_stat", fault_stat, fs);
            chk("R10 irq", irq, fs && irq_en);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_sel(input logic [1:0] v);
        cfg_we = 1'b1; cfg_div_sel = v; step(1); cfg_we = 1'b0;
    endtask

    // Stimulus.
    initial begin
        step(5);
        chk("R1 reset amp_shdn", amp_shdn, 3);
        chk("R1 reset sync_clk", sync_clk, 0);
        chk("R1 reset ready", ready, 0);
        chk("R1 reset dac_codes", dac_codes, {10'd512, 10'd512});
        chk("R1 reset fault_stat", fault_stat, 0);
        chk("R1 reset irq", irq, 0);
        rst_n = 1'b1;
        user_codes = {10'd100, 10'd700};
        step(4);
        write_sel(2'd1);
        step(6);
        start = 1'b1; step(1); start = 1'b0;
        step(50);
        start = 1'b1; step(1); start = 1'b0;       // R11: ignored
        write_sel(2'd3);                           // R3: change while running
        step(TU - 100);
        chk("R4 still shut before release", amp_shdn, 3);
        step(60);
        chk("R4 released", amp_shdn, 0);
        step(TU + 20);
        chk("R5 ready after second wait", ready, 1);
        write_sel(2'd2); step(30);
        write_sel(2'd3); step(30);
        write_sel(2'd0); step(15);
        write_sel(2'd2); step(20);
        // R8: single event, active channel
        fault_evt = 2'b01; step(1); fault_evt = 2'b00; step(10);
        // R9: event on a shut channel is ignored
        shdn_req = 2'b01;
        fault_evt = 2'b01; step(1); fault_evt = 2'b00; step(10);
        chk("R9 masked event", fault_stat, 0);
        // R10: interrupt with enable, event held 3 cycles
        irq_en = 1'b1;
        fault_evt = 2'b10; step(3); fault_evt = 2'b00; step(2);
        chk("R10 irq raised", irq, 1);
        step(10);
        // R9: both shut clears a live status; R7 stops the sync clock
        fault_evt = 2'b10; step(1); fault_evt = 2'b00;
        shdn_req = 2'b11; step(1);
        fault_evt = 2'b11; step(2); fault_evt = 2'b00;
        step(20);
        chk("R7 sync stopped", sync_clk, 0);
        shdn_req = 2'b00; step(20);
        user_codes = {10'd1023, 10'd0}; step(5);
        user_codes = {10'd512, 10'd511}; step(5);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule